// File: doc/BRIEF.md
# Split-Half Bidirectional Latch/Register Transceiver

This block is the datapath of a two-way bus transceiver. Data travels from the A side to the B side and, separately, from the B side to the A side. Each direction contains one storage element per half-bus. The element follows its input while its latch-enable is high. It keeps its value while latch-enable is low and the direction clock does not change. It takes a new value on a rising edge of the direction clock while latch-enable is low. The direction clock and the latch-enable are level inputs that the block samples on the system clock `clk_i`, so a rising direction clock is recognised as a low-to-high change between two samples.

The bus is split into halves of `HALF_W` bits, two by default. Each half has its own latch-enable, direction clock and active-low output-enable for each direction. Tying the control sets together makes the block act as one full-width transceiver. Each output side is a data vector plus a per-bit enable vector, so the surrounding logic or a bench can resolve tri-state values without real pads. A test-mode input replaces the output data of both directions with externally supplied values. The output enables still follow the output-enable inputs.

Top module: `bus_xcvr_top`

## Requirements
- R1: When a half's latch-enable is high and test mode is off, that half's output data equals the current input of that half in the same cycle.
- R2: When a half's latch-enable is low and its direction clock shows no low-to-high change between samples, the stored value and the output data of that half do not change.
- R3: When a half's latch-enable is low and its direction clock goes from low in one sample to high in the next, the input present at that clock edge is stored and appears on the output after that edge.
- R4: A rising direction clock while latch-enable is high stores the current input, so the value held after latch-enable falls is the last input seen while it was high.
- R5: Every enable bit of a half is 1 when that half's active-low output-enable is 0, and 0 when it is 1. The data bits are still presented while the enable is 0.
- R6: The B-to-A direction behaves exactly as the A-to-B direction, using its own latch-enable, direction clock and output-enable.
- R7: Each half responds only to its own control set; activity on the other half's controls leaves it unchanged.
- R8: While test mode is high, the output data of both directions equals the forced test vectors, and the enables still follow the output-enables. When test mode drops, the stored or transparent data returns.
- R9: An active-low reset clears all stored values to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples all controls |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_i | input | 18 | A-side input data |
| b_i | input | 18 | B-side input data |
| ab_le_i | input | 2 | A-to-B latch-enable, one per half |
| ab_clk_i | input | 2 | A-to-B direction clock, one per half |
| ab_oe_ni | input | 2 | A-to-B active-low output-enable, one per half |
| ba_le_i | input | 2 | B-to-A latch-enable, one per half |
| ba_clk_i | input | 2 | B-to-A direction clock, one per half |
| ba_oe_ni | input | 2 | B-to-A active-low output-enable, one per half |
| test_mode_i | input | 1 | Replaces output data with the forced vectors |
| test_a_i | input | 18 | Forced data for the A-side outputs |
| test_b_i | input | 18 | Forced data for the B-side outputs |
| b_o | output | 18 | B-side output data |
| b_en_o | output | 18 | B-side per-bit drive enable |
| a_o | output | 18 | A-side output data |
| a_en_o | output | 18 | A-side per-bit drive enable |

## Verification
The A-to-B path is driven through a sequence that alternates transparent, hold and capture rows. The input changes on each row, so a hold is told apart from a capture and from a transparent pass. Split-control rows give one half a clock edge or a transparent phase while the other half holds, which shows whether the halves leak into each other. One row raises the direction clock while latch-enable is high, which tells whether the last transparent value is the one that remains stored. Directed steps then repeat transparent, capture and hold on the B-to-A path, toggle test mode over stored data, and apply reset during operation.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned HALF_W_DEF = 9;
  localparam int unsigned HALVES_DEF = 2;
endpackage

// File: rtl/xcvr_cell.sv
module xcvr_cell #(
  parameter int unsigned W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         le_i,
  input  logic         dclk_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] data_o
);
  logic         dclk_q;
  logic [W-1:0] q;
  logic         rise;

  assign rise = dclk_i & ~dclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dclk_q <= 1'b0;
      q      <= '0;
    end else begin
      dclk_q <= dclk_i;
      // transparent phase tracks input so the value at latch close is kept
      if (le_i || rise) q <= d_i;
    end
  end

  assign q_o    = q;
  assign data_o = le_i ? d_i : q;

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && !dclk_i) |=> $stable(q));

  assert_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && $rose(dclk_i)) |=> (q == $past(d_i)));

  assert_open_store_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_i |=> (q == $past(d_i)));
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path #(
  parameter int unsigned HALF_W = xcvr_pkg::HALF_W_DEF,
  parameter int unsigned HALVES = xcvr_pkg::HALVES_DEF,
  localparam int unsigned W     = HALF_W * HALVES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HALVES-1:0] le_i,
  input  logic [HALVES-1:0] dclk_i,
  input  logic [HALVES-1:0] oe_ni,
  input  logic [W-1:0]      d_i,
  input  logic              test_i,
  input  logic [W-1:0]      force_i,
  output logic [W-1:0]      data_o,
  output logic [W-1:0]      en_o
);
  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic [HALF_W-1:0] cell_q;
    logic [HALF_W-1:0] cell_data;

    xcvr_cell #(.W(HALF_W)) i_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .le_i   (le_i[h]),
      .dclk_i (dclk_i[h]),
      .d_i    (d_i[h*HALF_W +: HALF_W]),
      .q_o    (cell_q),
      .data_o (cell_data)
    );

    assign data_o[h*HALF_W +: HALF_W] = test_i ? force_i[h*HALF_W +: HALF_W] : cell_data;
    assign en_o[h*HALF_W +: HALF_W]   = {HALF_W{~oe_ni[h]}};

    assert_transparent_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (le_i[h] && !test_i) |-> (data_o[h*HALF_W +: HALF_W] == d_i[h*HALF_W +: HALF_W]));

    assert_enable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      oe_ni[h] |-> (en_o[h*HALF_W +: HALF_W] == '0));

    assert_closed_out_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!le_i[h] && !test_i) |-> (data_o[h*HALF_W +: HALF_W] == cell_q));
  end

  assert_force_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_i |-> (data_o == force_i));
endmodule

// File: rtl/bus_xcvr_top.sv
module bus_xcvr_top #(
  parameter int unsigned HALF_W = xcvr_pkg::HALF_W_DEF,
  parameter int unsigned HALVES = xcvr_pkg::HALVES_DEF,
  localparam int unsigned W     = HALF_W * HALVES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  input  logic [HALVES-1:0] ab_le_i,
  input  logic [HALVES-1:0] ab_clk_i,
  input  logic [HALVES-1:0] ab_oe_ni,
  input  logic [HALVES-1:0] ba_le_i,
  input  logic [HALVES-1:0] ba_clk_i,
  input  logic [HALVES-1:0] ba_oe_ni,
  input  logic              test_mode_i,
  input  logic [W-1:0]      test_a_i,
  input  logic [W-1:0]      test_b_i,
  output logic [W-1:0]      b_o,
  output logic [W-1:0]      b_en_o,
  output logic [W-1:0]      a_o,
  output logic [W-1:0]      a_en_o
);
  xcvr_path #(.HALF_W(HALF_W), .HALVES(HALVES)) i_ab (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .le_i    (ab_le_i),
    .dclk_i  (ab_clk_i),
    .oe_ni   (ab_oe_ni),
    .d_i     (a_i),
    .test_i  (test_mode_i),
    .force_i (test_b_i),
    .data_o  (b_o),
    .en_o    (b_en_o)
  );

  xcvr_path #(.HALF_W(HALF_W), .HALVES(HALVES)) i_ba (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .le_i    (ba_le_i),
    .dclk_i  (ba_clk_i),
    .oe_ni   (ba_oe_ni),
    .d_i     (b_i),
    .test_i  (test_mode_i),
    .force_i (test_a_i),
    .data_o  (a_o),
    .en_o    (a_en_o)
  );

  assert_b_to_a_enable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ba_oe_ni == '0) |-> (a_en_o == '1));
endmodule

// File: tb/test_bus_xcvr_top.sv
module test_bus_xcvr_top;
  localparam int W = 18;

  typedef struct packed {
    logic [1:0]   le;
    logic [1:0]   dclk;
    logic [1:0]   oe_n;
    logic [W-1:0] a;
    logic [W-1:0] exp_b;
    logic [W-1:0] exp_en;
    logic [3:0]   req;
  } vec_t;

  // req: 1=R1 2=R2 3=R3 4=R4 5=R5 7=R7
  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{2'b11, 2'b00, 2'b00, 18'h12345, 18'h12345, 18'h3FFFF, 4'd1},
    '{2'b00, 2'b00, 2'b00, 18'h3FFFF, 18'h12345, 18'h3FFFF, 4'd2},
    '{2'b00, 2'b11, 2'b00, 18'h2AAAA, 18'h2AAAA, 18'h3FFFF, 4'd3},
    '{2'b00, 2'b11, 2'b00, 18'h15555, 18'h2AAAA, 18'h3FFFF, 4'd2},
    '{2'b00, 2'b00, 2'b00, 18'h15555, 18'h2AAAA, 18'h3FFFF, 4'd2},
    '{2'b00, 2'b01, 2'b00, 18'h0F0F0, 18'h2AAF0, 18'h3FFFF, 4'd7},
    '{2'b10, 2'b01, 2'b00, 18'h3C0C3, 18'h3C0F0, 18'h3FFFF, 4'd7},
    '{2'b00, 2'b00, 2'b01, 18'h00000, 18'h3C0F0, 18'h3FE00, 4'd5},
    '{2'b00, 2'b00, 2'b11, 18'h00000, 18'h3C0F0, 18'h00000, 4'd5},
    '{2'b11, 2'b11, 2'b00, 18'h0ABCD, 18'h0ABCD, 18'h3FFFF, 4'd4},
    '{2'b00, 2'b11, 2'b00, 18'h00000, 18'h0ABCD, 18'h3FFFF, 4'd4}
  };

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0, test_a_i = '0, test_b_i = '0;
  logic [1:0]   ab_le_i = '0, ab_clk_i = '0, ab_oe_ni = 2'b11;
  logic [1:0]   ba_le_i = '0, ba_clk_i = '0, ba_oe_ni = 2'b11;
  logic         test_mode_i = 1'b0;
  logic [W-1:0] b_o, b_en_o, a_o, a_en_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  bus_xcvr_top i_bus_xcvr_top (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .a_i         (a_i),
    .b_i         (b_i),
    .ab_le_i     (ab_le_i),
    .ab_clk_i    (ab_clk_i),
    .ab_oe_ni    (ab_oe_ni),
    .ba_le_i     (ba_le_i),
    .ba_clk_i    (ba_clk_i),
    .ba_oe_ni    (ba_oe_ni),
    .test_mode_i (test_mode_i),
    .test_a_i    (test_a_i),
    .test_b_i    (test_b_i),
    .b_o         (b_o),
    .b_en_o      (b_en_o),
    .a_o         (a_o),
    .a_en_o      (a_en_o)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %05h expected %05h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #2;
    // R9 reset state
    check("R9 reset b_o", b_o, '0);
    check("R9 reset a_o", a_o, '0);
    check("R5 reset b_en", b_en_o, '0);
    rst_ni = 1'b1;
    tick();

    for (int i = 0; i < NV; i++) begin
      ab_le_i  = TBL[i].le;
      ab_clk_i = TBL[i].dclk;
      ab_oe_ni = TBL[i].oe_n;
      a_i      = TBL[i].a;
      tick();
      check($sformatf("R%0d row %0d b_o", TBL[i].req, i), b_o, TBL[i].exp_b);
      check($sformatf("R%0d row %0d b_en", TBL[i].req, i), b_en_o, TBL[i].exp_en);
    end

    // R6 B-to-A: transparent, capture, hold
    ba_oe_ni = 2'b00;
    ba_le_i  = 2'b11;
    b_i      = 18'h1F00F;
    #1;
    check("R6 transparent a_o", a_o, 18'h1F00F);
    tick();
    check("R6 enable a_en", a_en_o, 18'h3FFFF);
    ba_le_i = 2'b00;
    b_i     = 18'h00777;
    tick();
    check("R6 hold a_o", a_o, 18'h1F00F);
    ba_clk_i = 2'b11;
    tick();
    check("R6 capture a_o", a_o, 18'h00777);
    b_i = 18'h3FFFF;
    tick();
    check("R6 held clk a_o", a_o, 18'h00777);

    // R8 test mode forces data, enables unchanged
    test_b_i    = 18'h2DEAD;
    test_a_i    = 18'h1BEEF;
    test_mode_i = 1'b1;
    tick();
    check("R8 forced b_o", b_o, 18'h2DEAD);
    check("R8 forced a_o", a_o, 18'h1BEEF);
    check("R8 b_en kept", b_en_o, 18'h3FFFF);
    test_mode_i = 1'b0;
    tick();
    check("R8 release b_o", b_o, 18'h0ABCD);
    check("R8 release a_o", a_o, 18'h00777);

    // R9 reset during operation
    rst_ni = 1'b0;
    #1;
    check("R9 mid reset b_o", b_o, '0);
    check("R9 mid reset a_o", a_o, '0);
    tick();

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule